// File: doc/BRIEF.md
# Three-Phase Gate Control Interlock

This block is the digital control core of a three-phase half-bridge gate driver. Each phase has a high-side request and a low-side request. The block turns them into a registered high-side gate enable and a registered low-side gate enable. Between switching one transistor of a leg off and its partner on, the block holds both enables low for a dead-time interval. It also refuses to drive both transistors of a leg at once. A global high-side chopping input gives slow-decay PWM with synchronous rectification. While that input is low, every high side that would be on is dropped and the low side of the same leg takes over.

A two-bit selector chooses among three dead-time modes. In programmed mode the interval is a cycle count taken from an input. In default mode it is a fixed cycle count set by a parameter. With the default settings that count is 750 cycles, which is 6 us at 125 MHz. In disabled mode no interval is added, and the outputs follow the relative timing of the requests. The shoot-through lockout can be bypassed only when dead time is disabled and the cross-conduction enable is high.

Each leg runs its own state machine with five states: IDLE (both off), HIGH, LOW, DEAD (both off while a per-leg down-counter runs) and BOTH (both on, bypass only). The named transitions are:
- turn-on: IDLE to HIGH, LOW or BOTH.
- release: HIGH, LOW or BOTH to DEAD when the wanted state differs and the interval is nonzero.
- direct-switch: HIGH, LOW or BOTH straight to the wanted state when the interval is zero or dead time is disabled.
- expiry: DEAD to the wanted state when the counter runs out, or at once in disabled mode.

Top module: `gate_interlock_3ph`

## Requirements
- R1: A synchronous active-low reset drives all six gate enables low and clears every dead-time counter. After reset is released, a request starts driving its enable one cycle later, with no dead interval left over from before the reset.
- R2: Each leg is independent. The high-side request of a leg affects only that leg's high-side enable, and the low-side request only that leg's low-side enable. From the idle state an enable goes high in the cycle after its request is sampled.
- R3: In programmed mode (dt_mode = 2'b00), after an enable of a leg falls, both enables of that leg stay low for exactly dt_count cycles before the complementary enable rises.
- R4: In default mode (dt_mode = 2'b01), the interval is DEFAULT_DT_CYCLES cycles, and dt_count has no effect.
- R5: In disabled mode (dt_mode = 2'b10), no interval is added. Each enable equals its lockout-filtered request one cycle later.
- R6: While the lockout is active, a leg with both requests high drives both enables low.
- R7: The lockout is bypassed only when dt_mode = 2'b10 and xcond_en = 1. Then both enables of a leg may be high together. In any other mode xcond_en has no effect.
- R8: While pwm_hi is low, a leg with its high-side request high has its high-side enable low and its low-side enable high. The low side rises only after the dead interval of the active mode.
- R9: While pwm_hi is low, a leg whose high-side request is low behaves as if pwm_hi were high.
- R10: A turn-on request that arrives during a running dead interval waits until the interval expires. The interval is still counted from the fall of the previous enable.
- R11: In programmed mode with dt_count = 0, the complementary enable rises in the same cycle that the other one falls, and the two are never high together.
- R12: dt_mode = 2'b11 behaves exactly like default mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_req | input | PHASES | High-side request per leg |
| lo_req | input | PHASES | Low-side request per leg |
| pwm_hi | input | 1 | High-side chopping input; low forces recirculation through the low sides |
| dt_mode | input | 2 | Dead-time mode: 00 programmed, 01 default, 10 disabled, 11 default |
| dt_count | input | CW | Programmed dead-time length in cycles |
| xcond_en | input | 1 | Cross-conduction enable, honoured only in disabled mode |
| gate_hi | output | PHASES | Registered high-side gate enables |
| gate_lo | output | PHASES | Registered low-side gate enables |

## Verification
The hardest case to reach from the ports is a request that changes while a leg is inside its dead interval. In that case the wanted state moves from idle to a turn-on partway through the countdown, and the rise must still line up with the original release. The bench reaches it by releasing a high side with no partner request and then raising the low-side request a fixed number of sampled cycles later. It counts the both-off cycles from the fall and compares the count with the programmed length. The PWM-driven handover is reached the same way: a leg is held high, pwm_hi is dropped, and the bench measures the gap in both directions. Exhaustive sweeps over all 64 request patterns in disabled mode cover the lockout, the bypass and the chopping map.

// File: rtl/gi_pkg.sv
package gi_pkg;

    localparam logic [1:0] MODE_PROG = 2'b00;
    localparam logic [1:0] MODE_DFLT = 2'b01;
    localparam logic [1:0] MODE_DIS  = 2'b10;

    typedef enum logic [1:0] {
        W_NONE,
        W_HIGH,
        W_LOW,
        W_BOTH
    } want_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_DEAD,
        ST_BOTH
    } leg_st_t;

endpackage

// File: rtl/gi_dt_select.sv
module gi_dt_select #(
    parameter int CW                = 10,
    parameter int DEFAULT_DT_CYCLES = 750
) (
    input  logic [1:0]    dt_mode,
    input  logic [CW-1:0] dt_count,
    input  logic          xcond_en,
    output logic [CW-1:0] dt_cycles,
    output logic          bypass_dt,
    output logic          lockout_on
);
    import gi_pkg::*;

    localparam logic [CW-1:0] DFLT_CNT = CW'(DEFAULT_DT_CYCLES);

    always_comb begin
        bypass_dt = (dt_mode == MODE_DIS);
        unique case (dt_mode)
            MODE_PROG: dt_cycles = dt_count;
            MODE_DIS:  dt_cycles = '0;
            default:   dt_cycles = DFLT_CNT;
        endcase
        lockout_on = !(bypass_dt && xcond_en);
    end

endmodule

// File: rtl/gi_req_shaper.sv
module gi_req_shaper #(
    parameter int PHASES = 3
) (
    input  logic [PHASES-1:0] hi_req,
    input  logic [PHASES-1:0] lo_req,
    input  logic              pwm_hi,
    input  logic              lockout_on,
    output gi_pkg::want_t     want [PHASES]
);
    import gi_pkg::*;

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        logic eff_hi;
        logic eff_lo;

        always_comb begin
            // Chopping: a requested high side hands over to its low side.
            eff_hi = hi_req[p] && pwm_hi;
            eff_lo = lo_req[p] || (hi_req[p] && !pwm_hi);

            unique case ({eff_hi, eff_lo})
                2'b10:   want[p] = W_HIGH;
                2'b01:   want[p] = W_LOW;
                2'b11:   want[p] = lockout_on ? W_NONE : W_BOTH;
                default: want[p] = W_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gi_leg_fsm.sv
module gi_leg_fsm #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  gi_pkg::want_t want,
    input  logic          bypass_dt,
    input  logic [CW-1:0] dt_cycles,
    output logic          gate_hi,
    output logic          gate_lo
);
    import gi_pkg::*;

    leg_st_t       state_q, state_d, tgt;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        unique case (want)
            W_HIGH:  tgt = ST_HIGH;
            W_LOW:   tgt = ST_LOW;
            W_BOTH:  tgt = ST_BOTH;
            default: tgt = ST_IDLE;
        endcase

        state_d = state_q;
        cnt_d   = cnt_q;

        unique case (state_q)
            ST_IDLE: begin
                // turn-on
                state_d = tgt;
            end
            ST_HIGH, ST_LOW, ST_BOTH: begin
                if (tgt != state_q) begin
                    if (bypass_dt || dt_cycles == '0) begin
                        // direct-switch
                        state_d = tgt;
                    end else begin
                        // release
                        state_d = ST_DEAD;
                        cnt_d   = dt_cycles;
                    end
                end
            end
            ST_DEAD: begin
                if (bypass_dt || cnt_q <= CW'(1)) begin
                    // expiry
                    state_d = tgt;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Output decode from the registered state
    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        unique case (state_q)
            ST_HIGH: gate_hi = 1'b1;
            ST_LOW:  gate_lo = 1'b1;
            ST_BOTH: begin
                gate_hi = 1'b1;
                gate_lo = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gate_interlock_3ph.sv
module gate_interlock_3ph #(
    parameter int PHASES            = 3,
    parameter int CW                = 10,
    parameter int DEFAULT_DT_CYCLES = 750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] hi_req,
    input  logic [PHASES-1:0] lo_req,
    input  logic              pwm_hi,
    input  logic [1:0]        dt_mode,
    input  logic [CW-1:0]     dt_count,
    input  logic              xcond_en,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo
);
    import gi_pkg::*;

    logic [CW-1:0] dt_cycles;
    logic          bypass_dt;
    logic          lockout_on;
    want_t         want [PHASES];

    gi_dt_select #(
        .CW               (CW),
        .DEFAULT_DT_CYCLES(DEFAULT_DT_CYCLES)
    ) u_dt_sel (
        .dt_mode   (dt_mode),
        .dt_count  (dt_count),
        .xcond_en  (xcond_en),
        .dt_cycles (dt_cycles),
        .bypass_dt (bypass_dt),
        .lockout_on(lockout_on)
    );

    gi_req_shaper #(
        .PHASES(PHASES)
    ) u_shaper (
        .hi_req    (hi_req),
        .lo_req    (lo_req),
        .pwm_hi    (pwm_hi),
        .lockout_on(lockout_on),
        .want      (want)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        gi_leg_fsm #(
            .CW(CW)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .want     (want[p]),
            .bypass_dt(bypass_dt),
            .dt_cycles(dt_cycles),
            .gate_hi  (gate_hi[p]),
            .gate_lo  (gate_lo[p])
        );
    end

endmodule

// File: rtl/gi_checker.sv
module gi_checker #(
    parameter int PHASES = 3,
    parameter int CW     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PHASES-1:0] hi_req,
    input logic [PHASES-1:0] lo_req,
    input logic              pwm_hi,
    input logic [1:0]        dt_mode,
    input logic              xcond_en,
    input logic [CW-1:0]     dt_cycles,
    input logic [PHASES-1:0] gate_hi,
    input logic [PHASES-1:0] gate_lo
);
    import gi_pkg::*;

    logic bypass_ok;
    assign bypass_ok = (dt_mode == MODE_DIS) && xcond_en;

    a_r1_reset_off: assert property (@(posedge clk)
        !rst_n |=> (gate_hi == '0 && gate_lo == '0));

    a_r8_pwm_drops_high: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_hi |=> (gate_hi == '0));

    a_r5_disabled_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_mode == MODE_DIS && pwm_hi) |=>
            (gate_hi == $past(hi_req & (~lo_req | {PHASES{xcond_en}})) &&
             gate_lo == $past(lo_req & (~hi_req | {PHASES{xcond_en}}))));

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_hi[p] && gate_lo[p]) |-> $past(bypass_ok));

        a_r3_gap_after_high: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(gate_hi[p]) && $past(dt_mode) != MODE_DIS && $past(dt_cycles) != '0)
                |-> !gate_lo[p]);

        a_r3_gap_after_low: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(gate_lo[p]) && $past(dt_mode) != MODE_DIS && $past(dt_cycles) != '0)
                |-> !gate_hi[p]);
    end

endmodule

bind gate_interlock_3ph gi_checker #(
    .PHASES(PHASES),
    .CW    (CW)
) u_gi_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_req   (hi_req),
    .lo_req   (lo_req),
    .pwm_hi   (pwm_hi),
    .dt_mode  (dt_mode),
    .xcond_en (xcond_en),
    .dt_cycles(dt_cycles),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo)
);

// File: tb/gate_interlock_3ph_tb.sv
module gate_interlock_3ph_tb;

    localparam int PHASES = 3;
    localparam int CW     = 6;
    localparam int DFLT   = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [PHASES-1:0] hi_req;
    logic [PHASES-1:0] lo_req;
    logic              pwm_hi;
    logic [1:0]        dt_mode;
    logic [CW-1:0]     dt_count;
    logic              xcond_en;
    logic [PHASES-1:0] gate_hi;
    logic [PHASES-1:0] gate_lo;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    gate_interlock_3ph #(
        .PHASES           (PHASES),
        .CW               (CW),
        .DEFAULT_DT_CYCLES(DFLT)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_req  (hi_req),
        .lo_req  (lo_req),
        .pwm_hi  (pwm_hi),
        .dt_mode (dt_mode),
        .dt_count(dt_count),
        .xcond_en(xcond_en),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Move leg p from one side to the other; return both-off cycles and overlap cycles.
    task automatic swap_gap(input int p, input bit from_hi, output int gap, output int ovl);
        gap = 0;
        ovl = 0;
        if (from_hi) hi_req[p] = 1'b1; else lo_req[p] = 1'b1;
        step();
        if (from_hi) begin hi_req[p] = 1'b0; lo_req[p] = 1'b1; end
        else         begin lo_req[p] = 1'b0; hi_req[p] = 1'b1; end
        step();
        while (!(from_hi ? gate_lo[p] : gate_hi[p]) && gap < 100) begin
            if (gate_hi[p] || gate_lo[p]) ovl++;
            gap++;
            step();
        end
        if (gate_hi[p] && gate_lo[p]) ovl++;
        hi_req = '0;
        lo_req = '0;
        repeat (40) step();
    endtask

    initial begin
        int gap;
        int ovl;
        int cnt;
        rst_n    = 1'b0;
        hi_req   = '0;
        lo_req   = '0;
        pwm_hi   = 1'b1;
        dt_mode  = 2'b00;
        dt_count = '0;
        xcond_en = 1'b0;
        repeat (4) step();
        chk("R1 reset gates", {gate_hi, gate_lo}, 0);
        rst_n = 1'b1;
        step();

        // R2: turn-on from idle, one leg only
        hi_req[1] = 1'b1;
        step();
        chk("R2 single leg high", {gate_hi, gate_lo}, 6'b010_000);
        hi_req = '0;
        repeat (40) step();

        // R3: programmed gap over several lengths, every leg, both directions
        foreach (hi_req[p]) begin
            for (int n = 1; n <= 7; n += 3) begin
                dt_count = CW'(n);
                swap_gap(p, 1'b1, gap, ovl);
                chk("R3 gap high-to-low", gap, n);
                chk("R3 no overlap", ovl, 0);
                swap_gap(p, 1'b0, gap, ovl);
                chk("R3 gap low-to-high", gap, n);
            end
        end

        // R11: zero programmed count
        dt_count = '0;
        swap_gap(0, 1'b1, gap, ovl);
        chk("R11 zero gap", gap, 0);
        chk("R11 no overlap", ovl, 0);

        // R4 / R12: default length, dt_count ignored
        dt_count = CW'(3);
        dt_mode  = 2'b01;
        swap_gap(2, 1'b1, gap, ovl);
        chk("R4 default gap", gap, DFLT);
        dt_count = CW'(40);
        swap_gap(1, 1'b0, gap, ovl);
        chk("R4 default gap other count", gap, DFLT);
        dt_mode = 2'b11;
        swap_gap(0, 1'b1, gap, ovl);
        chk("R12 mode 11 gap", gap, DFLT);

        // R5: disabled mode, no gap
        dt_mode = 2'b10;
        swap_gap(1, 1'b1, gap, ovl);
        chk("R5 disabled gap", gap, 0);
        chk("R5 disabled no overlap", ovl, 0);

        // R10: partner request arrives mid-interval
        dt_mode  = 2'b00;
        dt_count = CW'(5);
        hi_req[1] = 1'b1;
        step();
        hi_req[1] = 1'b0;
        step();
        cnt = 0;
        repeat (2) begin
            if (!gate_lo[1] && !gate_hi[1]) cnt++;
            step();
        end
        lo_req[1] = 1'b1;
        while (!gate_lo[1] && cnt < 100) begin
            cnt++;
            step();
        end
        chk("R10 late request waits", cnt, 5);
        lo_req = '0;
        repeat (40) step();

        // R6 / R7: lockout in programmed mode, xcond_en ignored there
        dt_count = CW'(3);
        xcond_en = 1'b1;
        hi_req[0] = 1'b1;
        step();
        lo_req[0] = 1'b1;
        cnt = 0;
        repeat (10) begin
            step();
            if (gate_hi[0] || gate_lo[0]) cnt++;
        end
        chk("R6 both requested off", cnt, 0);
        chk("R7 xcond ignored outside disabled", {gate_hi[0], gate_lo[0]}, 0);
        hi_req = '0;
        lo_req = '0;
        xcond_en = 1'b0;
        repeat (10) step();

        // R8: chopping handover and return in programmed mode
        dt_count = CW'(4);
        hi_req[2] = 1'b1;
        step();
        pwm_hi = 1'b0;
        step();
        chk("R8 high dropped", gate_hi[2], 0);
        gap = 0;
        while (!gate_lo[2] && gap < 100) begin gap++; step(); end
        chk("R8 handover gap", gap, 4);
        pwm_hi = 1'b1;
        step();
        gap = 0;
        while (!gate_hi[2] && gap < 100) begin gap++; step(); end
        chk("R8 return gap", gap, 4);
        hi_req = '0;
        repeat (20) step();

        // R9: chopping with no high request leaves low side free
        pwm_hi = 1'b0;
        lo_req[1] = 1'b1;
        step();
        chk("R9 low follows request", {gate_hi, gate_lo}, 6'b000_010);
        lo_req = '0;
        step();
        chk("R9 all off", {gate_hi, gate_lo}, 0);
        pwm_hi = 1'b1;
        repeat (10) step();

        // R1: mid-run reset clears a running interval
        dt_count = CW'(20);
        hi_req[0] = 1'b1;
        step();
        hi_req[0] = 1'b0;
        step();
        rst_n = 1'b0;
        step();
        chk("R1 reset mid-run", {gate_hi, gate_lo}, 0);
        rst_n = 1'b1;
        lo_req[0] = 1'b1;
        step();
        chk("R1 counter cleared", gate_lo[0], 1);
        lo_req = '0;
        repeat (30) step();

        // Exhaustive request sweeps in disabled mode
        dt_mode = 2'b10;
        for (int s = 0; s < 3; s++) begin
            xcond_en = (s == 1);
            pwm_hi   = (s != 2);
            for (int v = 0; v < 64; v++) begin
                logic [2:0] h;
                logic [2:0] l;
                logic [2:0] eh;
                logic [2:0] el;
                h = v[2:0];
                l = v[5:3];
                hi_req = h;
                lo_req = l;
                step();
                if (s == 2) begin
                    eh = '0;
                    el = h | l;
                    chk("R8 chop sweep", {gate_hi, gate_lo}, {eh, el});
                end else if (s == 1) begin
                    chk("R7 bypass sweep", {gate_hi, gate_lo}, {h, l});
                end else begin
                    eh = h & ~l;
                    el = l & ~h;
                    chk("R6 lockout sweep", {gate_hi, gate_lo}, {eh, el});
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule